// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches a small group of external interrupt request pins. Each pin is brought into the clock domain through its own synchronizer. It is then sensed in one of four ways, chosen by a two-bit field per pin: low level, falling edge, rising edge, or both edges. When a pin's condition is detected, a per-pin request flag is set. The flag stays set until it is cleared, and it drives that pin's request line toward the interrupt controller.

A flag can be cleared in two ways. The interrupt controller can report, through a per-pin acknowledge, that the request was accepted. Software can also clear it with a read-then-write handshake: the status register must first be read while the flag shows 1, and a later write of 0 to that flag bit then clears it. A write of 0 that was not preceded by such a read does nothing. If a set and a clear fall in the same cycle, the set wins, so no request is lost.

Two registers sit on a simple register bus. The control register holds the sense fields. The status register holds the flags and the live synchronized pin levels.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, all request flags are 0, the control register reads 0 (every pin in low-level mode), and the synchronizers hold the idle-high pin level.
- R2: In low-level mode (field value 00), a pin held low sets its flag. The flag is visible on the third rising clock edge after the pin changes, because the pin passes two synchronizer flops and then the flag flop.
- R3: In falling-edge mode (field value 01), a high-to-low transition sets the flag and a low-to-high transition does not.
- R4: In rising-edge mode (field value 10), a low-to-high transition sets the flag and a high-to-low transition does not.
- R5: In both-edges mode (field value 11), either transition sets the flag.
- R6: A flag, once set, stays set after the pin's condition goes away, until it is cleared. A flag never sets without a detected condition.
- R7: A one-cycle pulse on the acknowledge bit of a pin clears its flag on the next clock edge, provided no new detection occurs in that cycle.
- R8: A read of the status register while a flag is 1, followed by a status write carrying 0 in that flag's bit, clears the flag.
- R9: A status write of 0 to a flag bit that was not read as 1 since the last status write leaves the flag set. Writing 1 to a flag bit never changes it. Any status write consumes the pending read.
- R10: Status bits [7:4] (bits [2N-1:N]) show the synchronized level of each pin, with pin i in bit N+i.
- R11: When a detection and a clear fall in the same cycle, the flag stays set. In low-level mode this means a flag whose pin is still low cannot be cleared.
- R12: Address 0 selects the control register, with pin i's sense field in bits [2i+1:2i]; it reads back what was written. Address 1 selects the status register, with flags in bits [N-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_PINS | Asynchronous external request pins |
| irq_ack | input | NUM_PINS | Per-pin acceptance pulse from the interrupt controller |
| irq_req | output | NUM_PINS | Per-pin request flags toward the interrupt controller |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel); arms the software clear |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 2*NUM_PINS | Write data |
| bus_rdata | output | 2*NUM_PINS | Read data for the addressed register |

## Verification
The assertions check, on every cycle, that a detection always leaves the flag set on the next edge, even when a clear is requested at the same time. They also check that an acknowledge with no competing detection always clears the flag, that no flag ever rises without a detection, and that the status read data always mirrors the request lines.

Some behaviour involves pin sequences, mode programming and the read-then-write ordering, and only the bench's scenarios can show it. This covers the exact latency through the synchronizer, which edges each mode ignores, a zero write that arrives without a prior read, and a write that consumes a pending read.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   localparam logic REG_CTRL = 1'b0;
   localparam logic REG_STAT = 1'b1;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ext_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import ext_irq_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   level_i,
   input  sense_e mode_i,
   input  logic   ack_i,
   input  logic   swclr_i,
   output logic   set_o,
   output logic   flag_o
);

   logic prev_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= level_i;
   end

   always_comb begin
      unique case (mode_i)
         SENSE_LOW:  set_o = ~level_i;
         SENSE_FALL: set_o = prev_q & ~level_i;
         SENSE_RISE: set_o = ~prev_q & level_i;
         SENSE_BOTH: set_o = prev_q ^ level_i;
         default:    set_o = 1'b0;
      endcase
   end

   // set has priority over either clear source
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_q <= 1'b0;
      else if (set_o)             flag_q <= 1'b1;
      else if (ack_i || swclr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS = 4,
   localparam int DW      = 2 * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic                bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NUM_PINS-1:0] flags_i,
   input  logic [NUM_PINS-1:0] levels_i,
   output logic [DW-1:0]       modes_o,
   output logic [NUM_PINS-1:0] swclr_o
);

   logic [DW-1:0]       ctrl_q;
   logic [NUM_PINS-1:0] armed_q;
   logic                wr_ctrl, wr_stat, rd_stat;

   assign wr_ctrl = bus_sel & bus_wr & (bus_addr == REG_CTRL);
   assign wr_stat = bus_sel & bus_wr & (bus_addr == REG_STAT);
   assign rd_stat = bus_sel & bus_rd & (bus_addr == REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata;
   end

   // a flag bit is armed once seen as 1 by a status read; a status write
   // consumes all arms, and an arm lapses when its flag drops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= '0;
      else if (wr_stat) armed_q <= '0;
      else              armed_q <= (rd_stat ? (armed_q | flags_i) : armed_q) & flags_i;
   end

   assign swclr_o   = {NUM_PINS{wr_stat}} & armed_q & ~bus_wdata[NUM_PINS-1:0];
   assign modes_o   = ctrl_q;
   assign bus_rdata = (bus_addr == REG_CTRL) ? ctrl_q : {levels_i, flags_i};

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int   NUM_PINS    = 4,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1,
   localparam int  DW          = 2 * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_pin,
   input  logic [NUM_PINS-1:0] irq_ack,
   output logic [NUM_PINS-1:0] irq_req,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic                bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata
);

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("ext_irq_detect: NUM_PINS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ext_irq_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] det_set;
   logic [NUM_PINS-1:0] sw_clear;
   logic [DW-1:0]       sense_modes;

   ext_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .flags_i   (irq_req),
      .levels_i  (pin_sync),
      .modes_o   (sense_modes),
      .swclr_o   (sw_clear)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      ext_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVEL)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (irq_pin[i]),
         .sync_o  (pin_sync[i])
      );

      ext_irq_sense #(.IDLE_LEVEL(IDLE_LEVEL)) u_sense (
         .clk     (clk),
         .rst_n   (rst_n),
         .level_i (pin_sync[i]),
         .mode_i  (sense_e'(sense_modes[2*i +: 2])),
         .ack_i   (irq_ack[i]),
         .swclr_i (sw_clear[i]),
         .set_o   (det_set[i]),
         .flag_o  (irq_req[i])
      );
   end

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
   parameter int  NUM_PINS = 4,
   localparam int DW       = 2 * NUM_PINS
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] irq_ack,
   input logic [NUM_PINS-1:0] irq_req,
   input logic [NUM_PINS-1:0] det_set,
   input logic                bus_addr,
   input logic [DW-1:0]       bus_rdata
);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_req == '0));

   assert_set_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (det_set != '0) |=> ((irq_req & $past(det_set)) == $past(det_set)));

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_ack & ~det_set) != '0) |=> ((irq_req & $past(irq_ack & ~det_set)) == '0));

   assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_req & ~$past(irq_req) & ~$past(det_set)) == '0));

   assert_status_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 1'b1) |-> (bus_rdata[NUM_PINS-1:0] == irq_req));

endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_ack   (irq_ack),
   .irq_req   (irq_req),
   .det_set   (det_set),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata)
);

// File: tb/ext_irq_detect_bench.sv
module ext_irq_detect_bench;

   localparam int N  = 4;
   localparam int DW = 2 * N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_pin = '1;
   logic [N-1:0]  irq_ack = '0;
   logic [N-1:0]  irq_req;
   logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_detect #(.NUM_PINS(N)) u_ext_irq_detect (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .irq_ack(irq_ack),
      .irq_req(irq_req), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic bus_write(input logic a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic drive_pins(input logic [N-1:0] p);
      irq_pin = p;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_ack(input logic [N-1:0] a);
      irq_ack = a;
      @(posedge clk); @(negedge clk);
      irq_ack = '0;
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      chk("R1 flags after reset", DW'(irq_req), '0);
      bus_read(1'b0, d);
      chk("R1 control after reset", d, '0);
      bus_read(1'b1, d);
      chk("R1 status after reset", d, 8'hF0);
   endtask

   task automatic t_regs;
      logic [DW-1:0] d;
      bus_write(1'b0, 8'h1B);
      bus_read(1'b0, d);
      chk("R12 control readback", d, 8'h1B);
   endtask

   task automatic t_fall;
      bus_write(1'b0, 8'h55);
      irq_pin = 4'b1110;
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R2 latency not yet", DW'(irq_req), 8'h00);
      @(posedge clk); @(negedge clk);
      chk("R3 falling sets flag", DW'(irq_req), 8'h01);
      drive_pins(4'b1111);
      chk("R6 flag held after rise", DW'(irq_req), 8'h01);
      pulse_ack(4'hF);
      chk("R7 ack clears", DW'(irq_req), 8'h00);
   endtask

   task automatic t_rise;
      bus_write(1'b0, 8'hAA);
      drive_pins(4'b1101);
      chk("R4 falling ignored", DW'(irq_req), 8'h00);
      drive_pins(4'b1111);
      chk("R4 rising sets", DW'(irq_req), 8'h02);
      pulse_ack(4'b0010);
      chk("R7 ack clears rise", DW'(irq_req), 8'h00);
   endtask

   task automatic t_both;
      bus_write(1'b0, 8'hFF);
      drive_pins(4'b1011);
      chk("R5 both falling", DW'(irq_req), 8'h04);
      pulse_ack(4'b0100);
      chk("R5 cleared", DW'(irq_req), 8'h00);
      drive_pins(4'b1111);
      chk("R5 both rising", DW'(irq_req), 8'h04);
      pulse_ack(4'b0100);
   endtask

   task automatic t_level;
      bus_write(1'b0, 8'h00);
      chk("R2 high pins no flag", DW'(irq_req), 8'h00);
      drive_pins(4'b0111);
      chk("R2 low level sets", DW'(irq_req), 8'h08);
      pulse_ack(4'b1000);
      chk("R11 set wins over ack", DW'(irq_req), 8'h08);
      drive_pins(4'b1111);
      chk("R6 level flag held", DW'(irq_req), 8'h08);
      pulse_ack(4'b1000);
      chk("R7 level flag cleared", DW'(irq_req), 8'h00);
   endtask

   task automatic t_sw_clear;
      logic [DW-1:0] d;
      bus_write(1'b0, 8'hFF);
      drive_pins(4'b1110);
      drive_pins(4'b1111);
      chk("R5 flag for sw test", DW'(irq_req), 8'h01);
      bus_write(1'b1, 8'h00);
      chk("R9 zero write without read", DW'(irq_req), 8'h01);
      bus_read(1'b1, d);
      chk("R10 status levels and flags", d, 8'hF1);
      bus_write(1'b1, 8'h0F);
      chk("R9 write one no effect", DW'(irq_req), 8'h01);
      bus_write(1'b1, 8'h00);
      chk("R9 arm consumed by write", DW'(irq_req), 8'h01);
      bus_read(1'b1, d);
      bus_write(1'b1, 8'h00);
      chk("R8 read then zero write clears", DW'(irq_req), 8'h00);
   endtask

   task automatic t_live;
      logic [DW-1:0] d;
      bus_write(1'b0, 8'hAA);
      irq_pin = 4'b1010;
      repeat (2) @(posedge clk); @(negedge clk);
      bus_read(1'b1, d);
      chk("R10 live levels", d, 8'hA0);
      drive_pins(4'b1111);
      chk("R4 rising on two pins", DW'(irq_req), 8'h05);
      pulse_ack(4'hF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_fall();
      t_rise();
      t_both();
      t_level();
      t_sw_clear();
      t_live();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule